// File: doc/BRIEF.md
# Index-Matching Sparse Systolic Processing Element

This block is one cell of a weight-stationary systolic array that multiplies a column-packed sparse matrix by a dense vector. Each cell holds a single nonzero weight, an 8-bit signed value, together with the 16-bit column index that the weight had before packing. Vector elements reach the cell one after another from its horizontal neighbour. Each element carries a value, an index and a flag that marks the last element of a group. The cell passes every element on to the next cell one cycle later, and it keeps the value whose index equals its own stored index.

When the last element of a group arrives, the cell either adds the product of its weight and the kept operand to the partial sum arriving from above, or passes that partial sum down unchanged. A cell loaded as a zero entry always passes the partial sum through. The kept operand is cleared at every group end. The next group can therefore start on the cycle right after a group end without disturbing the result that is still in flight. A load port writes the weight, its index and the zero-entry bit.

Top module: `spe_cell`

## Requirements
- R1: After reset, every output is zero and the cell acts as a zero entry: `psumOut` repeats `psumIn` one cycle later, even on group-end elements.
- R2: When `ldEn` is high at a clock edge, the weight value, index and zero-entry bit are written at that edge. The new weight governs elements from the next cycle onward.
- R3: `outValid`, `outValue`, `outIndex` and `outEnd` equal `inValid`, `inValue`, `inIndex` and `inEnd` of the previous cycle.
- R4: A valid element with `inEnd` = 0 whose index equals the stored index, on a cell that is not a zero entry, replaces the kept operand with its value.
- R5: A valid element whose index differs from the stored index leaves the kept operand unchanged.
- R6: A valid element with `inEnd` = 1 on a nonzero-entry cell makes `psumOut` on the next cycle equal to `psumIn + weight * operand`. Both factors are signed 8-bit values, and the sum is signed 32-bit.
- R7: If the group-end element's own index matches, its value is the operand used in that multiply-accumulate.
- R8: On a zero-entry cell, `psumOut` on the next cycle equals `psumIn`, whatever the input stream holds.
- R9: In any cycle without a valid group-end element, `psumOut` on the next cycle equals `psumIn`.
- R10: The kept operand is zero after reset and after every group end. A group with no matching element therefore yields `psumIn` unchanged.
- R11: Elements of the next group may arrive on the cycle right after a group end. The earlier result is not corrupted, and the new group's result depends only on its own elements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldEn | input | 1 | Weight write enable |
| ldValue | input | 8 | Signed weight value to store |
| ldIndex | input | 16 | Original column index of the weight |
| ldZero | input | 1 | Marks the stored weight as a zero entry |
| inValid | input | 1 | Stream element present |
| inValue | input | 8 | Signed vector value |
| inIndex | input | 16 | Vector element index |
| inEnd | input | 1 | Last element of the group |
| psumIn | input | 32 | Signed partial sum from the cell above |
| outValid | output | 1 | Forwarded element present |
| outValue | output | 8 | Forwarded vector value |
| outIndex | output | 16 | Forwarded vector index |
| outEnd | output | 1 | Forwarded group-end flag |
| psumOut | output | 32 | Signed partial sum to the cell below |

## Verification
The assertions check on every cycle the behaviours that hold cycle by cycle:
- forwarding of the stream,
- the pass-through of the partial sum outside group ends and in bypass,
- operand capture on a match and hold on a mismatch,
- clearing of the operand at a group end.

The arithmetic value of the multiply-accumulate can only be shown by the bench's scenarios. The bench sweeps signed weights across the full range against every 8-bit operand. Further scenarios cover a group-end element that matches, groups with no match, back-to-back groups and reloading a weight.

// File: rtl/spe_pkg.sv
package spe_pkg;

  typedef enum logic [1:0] {
    MODE_MISMATCH = 2'd0,
    MODE_MATCH    = 2'd1,
    MODE_MAC      = 2'd2,
    MODE_BYPASS   = 2'd3
  } peMode_e;

  typedef struct packed {
    logic captureOp;   // latch incoming value as operand
    logic clearOp;     // drop the operand after a group ends
    logic addProduct;  // add weight*operand to the partial sum
    logic selLive;     // use the incoming value instead of the stored operand
  } peStrobe_t;

endpackage

// File: rtl/spe_ctrl.sv
module spe_ctrl
  import spe_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             inValid,
  input  logic [IDX_W-1:0] inIndex,
  input  logic             inEnd,
  input  logic [IDX_W-1:0] wIndex,
  input  logic             wZero,
  output peMode_e          mode,
  output peStrobe_t        strobe
);

  logic idxHit;
  logic groupEnd;

  assign idxHit   = inValid && (inIndex == wIndex);
  assign groupEnd = inValid && inEnd;

  always_comb begin
    if (wZero)         mode = MODE_BYPASS;
    else if (groupEnd) mode = MODE_MAC;
    else if (idxHit)   mode = MODE_MATCH;
    else               mode = MODE_MISMATCH;
  end

  always_comb begin
    strobe            = '0;
    strobe.captureOp  = (mode == MODE_MATCH);
    strobe.clearOp    = groupEnd;
    strobe.addProduct = (mode == MODE_MAC);
    strobe.selLive    = idxHit;
  end

endmodule

// File: rtl/spe_datapath.sv
module spe_datapath
  import spe_pkg::*;
#(
  parameter int VAL_W  = 8,
  parameter int IDX_W  = 16,
  parameter int PSUM_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ldEn,
  input  logic signed [VAL_W-1:0]  ldValue,
  input  logic        [IDX_W-1:0]  ldIndex,
  input  logic                     ldZero,
  input  logic                     inValid,
  input  logic signed [VAL_W-1:0]  inValue,
  input  logic        [IDX_W-1:0]  inIndex,
  input  logic                     inEnd,
  input  logic signed [PSUM_W-1:0] psumIn,
  input  peStrobe_t                strobe,
  output logic        [IDX_W-1:0]  wIndex,
  output logic                     wZero,
  output logic                     outValid,
  output logic signed [VAL_W-1:0]  outValue,
  output logic        [IDX_W-1:0]  outIndex,
  output logic                     outEnd,
  output logic signed [PSUM_W-1:0] psumOut
);

  localparam int PROD_W = 2 * VAL_W;
  localparam int EXT_W  = PSUM_W - PROD_W;

  logic signed [VAL_W-1:0]  wValue;
  logic signed [VAL_W-1:0]  opndReg;
  logic signed [VAL_W-1:0]  opSel;
  logic signed [PROD_W-1:0] prod;
  logic signed [PSUM_W-1:0] prodExt;
  logic signed [PSUM_W-1:0] macSum;

  // stationary weight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wValue <= '0;
      wIndex <= '0;
      wZero  <= 1'b1;
    end else if (ldEn) begin
      wValue <= ldValue;
      wIndex <= ldIndex;
      wZero  <= ldZero;
    end
  end

  // operand register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 opndReg <= '0;
    else if (strobe.clearOp)   opndReg <= '0;
    else if (strobe.captureOp) opndReg <= inValue;
  end

  // multiply-accumulate
  assign opSel = strobe.selLive ? inValue : opndReg;
  assign prod  = wValue * opSel;

  generate
    if (EXT_W > 0) begin : g_ext
      assign prodExt = {{EXT_W{prod[PROD_W-1]}}, prod};
    end else begin : g_trunc
      assign prodExt = prod[PSUM_W-1:0];
    end
  endgenerate

  assign macSum = psumIn + prodExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  psumOut <= '0;
    else if (strobe.addProduct) psumOut <= macSum;
    else                        psumOut <= psumIn;
  end

  // horizontal forwarding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outValue <= '0;
      outIndex <= '0;
      outEnd   <= 1'b0;
    end else begin
      outValid <= inValid;
      outValue <= inValue;
      outIndex <= inIndex;
      outEnd   <= inEnd;
    end
  end

  // R4
  match_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inEnd && !wZero && inIndex == wIndex) |=> opndReg == $past(inValue));

  // R5
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inEnd && inIndex != wIndex) |=> $stable(opndReg));

  // R10
  op_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inEnd) |=> opndReg == '0);

endmodule

// File: rtl/spe_cell.sv
module spe_cell
  import spe_pkg::*;
#(
  parameter int VAL_W  = 8,
  parameter int IDX_W  = 16,
  parameter int PSUM_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ldEn,
  input  logic signed [VAL_W-1:0]  ldValue,
  input  logic        [IDX_W-1:0]  ldIndex,
  input  logic                     ldZero,
  input  logic                     inValid,
  input  logic signed [VAL_W-1:0]  inValue,
  input  logic        [IDX_W-1:0]  inIndex,
  input  logic                     inEnd,
  input  logic signed [PSUM_W-1:0] psumIn,
  output logic                     outValid,
  output logic signed [VAL_W-1:0]  outValue,
  output logic        [IDX_W-1:0]  outIndex,
  output logic                     outEnd,
  output logic signed [PSUM_W-1:0] psumOut
);

  peMode_e          mode;
  peStrobe_t        strobe;
  logic [IDX_W-1:0] wIndex;
  logic             wZero;

  spe_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .inValid (inValid),
    .inIndex (inIndex),
    .inEnd   (inEnd),
    .wIndex  (wIndex),
    .wZero   (wZero),
    .mode    (mode),
    .strobe  (strobe)
  );

  spe_datapath #(.VAL_W(VAL_W), .IDX_W(IDX_W), .PSUM_W(PSUM_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ldEn     (ldEn),
    .ldValue  (ldValue),
    .ldIndex  (ldIndex),
    .ldZero   (ldZero),
    .inValid  (inValid),
    .inValue  (inValue),
    .inIndex  (inIndex),
    .inEnd    (inEnd),
    .psumIn   (psumIn),
    .strobe   (strobe),
    .wIndex   (wIndex),
    .wZero    (wZero),
    .outValid (outValid),
    .outValue (outValue),
    .outIndex (outIndex),
    .outEnd   (outEnd),
    .psumOut  (psumOut)
  );

  // R3
  fwd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(inValid) && outValue == $past(inValue) &&
              outIndex == $past(inIndex) && outEnd == $past(inEnd)));

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BYPASS) |=> psumOut == $past(psumIn));

  // R9
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inEnd) |=> psumOut == $past(psumIn));

  // R6
  mac_only_on_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addProduct |-> (inValid && inEnd && !wZero));

endmodule

// File: tb/sim_spe_cell.sv
module sim_spe_cell;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               ldEn = 1'b0;
  logic signed [7:0]  ldValue = '0;
  logic [15:0]        ldIndex = '0;
  logic               ldZero = 1'b0;
  logic               inValid = 1'b0;
  logic signed [7:0]  inValue = '0;
  logic [15:0]        inIndex = '0;
  logic               inEnd = 1'b0;
  logic signed [31:0] psumIn = '0;
  logic               outValid;
  logic signed [7:0]  outValue;
  logic [15:0]        outIndex;
  logic               outEnd;
  logic signed [31:0] psumOut;

  int nChecks = 0;
  int nFails  = 0;

  // bench reference state
  int   mW = 0;
  int   mIdx = 0;
  logic mZero = 1'b1;
  int   mOp = 0;

  always #4 clk = ~clk;

  spe_cell u0 (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldValue(ldValue), .ldIndex(ldIndex),
    .ldZero(ldZero), .inValid(inValid), .inValue(inValue), .inIndex(inIndex),
    .inEnd(inEnd), .psumIn(psumIn), .outValid(outValid), .outValue(outValue),
    .outIndex(outIndex), .outEnd(outEnd), .psumOut(psumOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int w, input int idx, input logic z);
    @(negedge clk);
    ldEn = 1'b1; ldValue = 8'(w); ldIndex = 16'(idx); ldZero = z;
    inValid = 1'b0; inEnd = 1'b0; psumIn = 0;
    @(negedge clk);
    ldEn = 1'b0;
    mW = w; mIdx = idx; mZero = z;
  endtask

  task automatic step(input logic v, input int idx, input int val, input logic e,
                      input int ps, input string tag);
    int   exp;
    logic hit;
    @(negedge clk);
    inValid = v; inIndex = 16'(idx); inValue = 8'(val); inEnd = e; psumIn = ps;
    hit = v && (idx == mIdx);
    if (v && e && !mZero) exp = ps + mW * (hit ? val : mOp);
    else                  exp = ps;
    if (v && e)                mOp = 0;
    else if (hit && !mZero)    mOp = val;
    @(posedge clk); #1;
    chk(tag, int'(psumOut), exp);
    chk("R3 fwd", int'({outValid, outEnd}), int'({v, e}));
    chk("R3 fwd", int'(outValue), val);
    chk("R3 fwd", int'(outIndex), idx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 psumOut", int'(psumOut), 0);
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 outIndex", int'(outIndex), 0);
    @(negedge clk); rstN = 1'b1;
    // R1: zero entry after reset passes through even on a matching group end
    step(1, 0, 50, 1, 1234, "R1 bypass after reset");

    // R2 load, then R5 mismatch, R4 match, R6 mac
    load(3, 7, 1'b0);
    step(1, 5, 9, 0, 10, "R9 passthrough");
    step(1, 7, -4, 0, 20, "R4 match");
    step(1, 8, 100, 0, 30, "R5 mismatch");
    step(1, 9, 1, 1, 1000, "R6 mac");           // 1000 + 3*-4 = 988
    // R7 matching group-end element supplies the operand
    step(1, 7, 11, 1, -5, "R7 end match");      // -5 + 33
    // R10 no match in group: operand was cleared
    step(1, 2, 60, 0, 0, "R9 passthrough");
    step(1, 3, 61, 1, 77, "R10 no match");
    // R9 invalid elements and end flags without valid
    step(0, 7, 99, 1, -300, "R9 invalid end");
    step(0, 7, 99, 0, 400, "R9 invalid");
    // R11 back-to-back groups
    step(1, 7, 5, 0, 0, "R11 g1 match");
    step(1, 4, 0, 1, 100, "R11 g1 end");        // 115
    step(1, 7, -2, 0, 200, "R11 g2 match");
    step(1, 6, 0, 1, 300, "R11 g2 end");        // 294
    step(1, 1, 0, 1, 400, "R11 g3 empty");      // 400
    // R2 reload index: old index no longer matches
    load(-7, 300, 1'b0);
    step(1, 7, 10, 0, 0, "R2 old idx");
    step(1, 8, 0, 1, 50, "R2 old idx end");     // 50
    step(1, 300, 10, 1, 50, "R2 new idx");      // 50 - 70
    // R8 zero entry ignores a matching stream
    load(9, 300, 1'b1);
    step(1, 300, 12, 0, 1, "R8 bypass match");
    step(1, 300, 13, 1, 2, "R8 bypass end");
    step(1, 5, 13, 1, -9, "R8 bypass end");
    // R6 sweep: signed weights against every operand
    for (int w = -128; w <= 127; w += 15) begin
      load(w, 42, 1'b0);
      for (int x = -128; x <= 127; x++) begin
        step(1, 42, x, 0, 0, "R4 sweep capture");
        step(1, 41, 0, 1, x * 3 + 1000, "R6 sweep mac");
      end
    end
    load(127, 42, 1'b0);
    step(1, 42, -128, 1, -2147483647 + 20000, "R6 extreme");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule